// File: doc/BRIEF.md
# Watchdog and Interval Timer

An 8-bit up-counter that advances on ticks from a prescaler dividing the system clock by one of eight power-of-two ratios. In interval mode every counter wrap latches a sticky overflow flag and holds an interrupt line high until software clears that flag. In watchdog mode the same wrap emits a one-cycle reset request, gated by an external reset-enable input. The reset controller is outside the block. It turns that request into a system reset, and the reset clears the flag.

Software reaches two byte-wide registers over a small bus with read and write strobes: a control/status byte and the counter itself. A write only takes effect when the upper byte of a 16-bit write word carries a fixed key. Clearing the overflow flag takes a read that sees the flag set, followed later by a keyed write of 0 to the flag bit.

Top module: `wdt_timer`

## Requirements
- R1: After reset the control/status byte (address 0) reads 0x18, the counter (address 1) reads 0, and both `irq_o` and `rst_req_o` are low. An asserted reset clears a set overflow flag.
- R2: While the enable bit (control bit 5) is 0, the counter is held at 0 from the second clock edge after the disabling write onward. The prescaler is also held cleared.
- R3: Clock-select codes 0 to 7 (control bits 2:0) divide the clock by 2, 64, 128, 512, 2048, 8192, 32768 and 131072. After the enabling write edge E, the counter steps at edges E+D, E+2D, and so on.
- R4: A counter step from 0xFF to 0x00 sets the overflow flag (control bit 7).
- R5: The flag clears only on an accepted control write with bit 7 = 0 that follows a control read taken while the flag was 1, with no other accepted control write in between. Writing 1 to the flag changes nothing. If an overflow falls on the same edge as a clearing write, the flag stays set.
- R6: In interval mode (control bit 6 = 0), `irq_o` is high exactly while the flag is 1.
- R7: In watchdog mode (control bit 6 = 1), an overflow drives `rst_req_o` high for exactly one cycle if `rst_en_i` was 1, and not at all otherwise. `irq_o` stays low in this mode.
- R8: A write is accepted only if `bus_wdata[15:8]` equals the key 0x5A. Any other write leaves both registers unchanged.
- R9: An accepted counter write loads `bus_wdata[7:0]` and takes priority over a tick on the same edge. While the timer is disabled, the write is ignored.
- R10: Control bits 4 and 3 always read 1, and writes to them are ignored.
- R11: `bus_rdata` shows the control/status byte when `bus_addr` = 0 and the counter when `bus_addr` = 1.
- R12: The counter keeps counting after an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 control/status, 1 counter |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used to arm the flag clear |
| bus_wdata | input | 16 | Write word: key in upper byte, data in lower byte |
| bus_rdata | output | 8 | Read data of the selected register |
| rst_en_i | input | 1 | Allows the watchdog reset request |
| irq_o | output | 1 | Interval interrupt, level |
| rst_req_o | output | 1 | Watchdog reset request pulse |

## Verification
The critical collision is a counter wrap that lands on the same clock edge as a properly armed flag-clearing write. The bench enables the timer at a known edge with a divide-by-64 rate and preloads the counter with 0xFF. It then arms the clear with a status read and schedules the clearing write for exactly the 64th edge after enabling. The flag must survive, with `irq_o` still high and the counter at 0. A second read-then-write must then clear the flag. The cycle-level reference model judges every other cycle of the run as well.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned SEL_W     = 3;
   localparam int unsigned NUM_RATES = 1 << SEL_W;
   localparam int unsigned PRE_W     = 17;

   // log2 of the divide ratio for each clock-select code
   function automatic int unsigned rate_shift(input int unsigned code);
      case (code)
         0:       rate_shift = 1;
         1:       rate_shift = 6;
         2:       rate_shift = 7;
         3:       rate_shift = 9;
         4:       rate_shift = 11;
         5:       rate_shift = 13;
         6:       rate_shift = 15;
         default: rate_shift = 17;
      endcase
   endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
   import wdt_pkg::*;
#(
   parameter int unsigned DIV_W = PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   logic [DIV_W-1:0]     div_q;
   logic [NUM_RATES-1:0] done_vec;

   if (rate_shift(NUM_RATES - 1) > DIV_W) begin : g_width_bad
      $error("prescaler width too small for the slowest rate");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (!run) div_q <= '0;
      else           div_q <= div_q + 1'b1;
   end

   for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
      localparam int unsigned SH = rate_shift(i);
      assign done_vec[i] = &div_q[SH-1:0];
   end

   assign tick = run & done_vec[sel];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   assign wrap = run & tick & ~load & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (load)  cnt_q <= load_val;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
   import wdt_pkg::*;
#(
   parameter int unsigned     DAT_W = 8,
   parameter int unsigned     KEY_W = 8,
   parameter logic [KEY_W-1:0] KEY  = 8'h5A,
   localparam int unsigned    WD_W  = KEY_W + DAT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [WD_W-1:0]  bus_wdata,
   input  logic             wrap,
   input  logic             rst_en_i,
   output logic             run,
   output logic             wdog,
   output logic [SEL_W-1:0] sel,
   output logic             ovf,
   output logic             cnt_load,
   output logic             irq_o,
   output logic             rst_req_o,
   output logic [7:0]       csr_rd
);
   logic             key_ok, csr_wr, clear_ok;
   logic             ovf_q, armed_q, run_q, wdog_q, rst_q;
   logic [SEL_W-1:0] sel_q;

   assign key_ok   = (bus_wdata[WD_W-1:DAT_W] == KEY);
   assign csr_wr   = bus_wr & ~bus_addr & key_ok;
   assign cnt_load = bus_wr &  bus_addr & key_ok;
   assign clear_ok = csr_wr & ~bus_wdata[7] & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q   <= 1'b0;
         armed_q <= 1'b0;
         run_q   <= 1'b0;
         wdog_q  <= 1'b0;
         sel_q   <= '0;
         rst_q   <= 1'b0;
      end else begin
         if (wrap)          ovf_q <= 1'b1;
         else if (clear_ok) ovf_q <= 1'b0;

         if (csr_wr)                          armed_q <= 1'b0;
         else if (bus_rd && !bus_addr && ovf_q) armed_q <= 1'b1;

         if (csr_wr) begin
            wdog_q <= bus_wdata[6];
            run_q  <= bus_wdata[5];
            sel_q  <= bus_wdata[SEL_W-1:0];
         end

         rst_q <= wrap & wdog_q & rst_en_i;
      end
   end

   assign run       = run_q;
   assign wdog      = wdog_q;
   assign sel       = sel_q;
   assign ovf       = ovf_q;
   assign irq_o     = ovf_q & ~wdog_q;
   assign rst_req_o = rst_q;
   assign csr_rd    = {ovf_q, wdog_q, run_q, 2'b11, sel_q};
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
   import wdt_pkg::*;
#(
   parameter int unsigned      CNT_W = 8,
   parameter int unsigned      KEY_W = 8,
   parameter logic [KEY_W-1:0] KEY   = 8'h5A,
   localparam int unsigned     WD_W  = KEY_W + CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [WD_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             rst_en_i,
   output logic             irq_o,
   output logic             rst_req_o
);
   if (CNT_W < 8) begin : g_cnt_bad
      $error("counter must be at least one byte wide");
   end

   logic             run, wdog, ovf, cnt_load, tick, wrap;
   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] cnt;
   logic [7:0]       csr_rd;

   wdt_ctrl #(.DAT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .wrap(wrap), .rst_en_i(rst_en_i),
      .run(run), .wdog(wdog), .sel(sel), .ovf(ovf), .cnt_load(cnt_load),
      .irq_o(irq_o), .rst_req_o(rst_req_o), .csr_rd(csr_rd)
   );

   wdt_prescaler #(.DIV_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .tick(tick)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load(cnt_load),
      .load_val(bus_wdata[CNT_W-1:0]), .cnt(cnt), .wrap(wrap)
   );

   assign bus_rdata = bus_addr ? cnt : CNT_W'(csr_rd);
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
   parameter int unsigned      CNT_W = 8,
   parameter int unsigned      KEY_W = 8,
   parameter logic [KEY_W-1:0] KEY   = 8'h5A
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_addr,
   input logic                   bus_wr,
   input logic [KEY_W+CNT_W-1:0] bus_wdata,
   input logic [CNT_W-1:0]       bus_rdata,
   input logic                   rst_en_i,
   input logic                   irq_o,
   input logic                   rst_req_o,
   input logic [CNT_W-1:0]       cnt,
   input logic                   run,
   input logic                   wdog,
   input logic [2:0]             sel,
   input logic                   ovf
);
   logic keyed;
   assign keyed = (bus_wdata[KEY_W+CNT_W-1:CNT_W] == KEY);

   a_r2_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (&cnt) && !(bus_wr && bus_addr && keyed)) ##1 (cnt == '0) |-> ovf);

   a_r5_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf) |-> $past(bus_wr && !bus_addr && keyed && !bus_wdata[7]));

   a_r7_no_irq_in_wdog: assert property (@(posedge clk) disable iff (!rst_n)
      wdog |-> !irq_o);

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   a_r7_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> ($past(rst_en_i) && $past(wdog)));

   a_r8_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !keyed) |=> $stable({wdog, run, sel}));

   a_r10_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_addr |-> (bus_rdata[4:3] == 2'b11));
endmodule

bind wdt_timer wdt_timer_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_en_i(rst_en_i),
   .irq_o(irq_o), .rst_req_o(rst_req_o), .cnt(cnt), .run(run), .wdog(wdog),
   .sel(sel), .ovf(ovf)
);

// File: tb/wdt_timer_bench.sv
`timescale 1ns/1ps
module wdt_timer_bench;
   localparam logic [7:0] K = 8'h5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_addr = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        rst_en_i = 1'b0;
   logic        irq_o, rst_req_o;

   int total = 0;
   int bad = 0;
   int pulses = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wdt_timer u_wdt_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_en_i(rst_en_i), .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   // ---------------- behavioural reference model ----------------
   int shifts[8] = '{1, 6, 7, 9, 11, 13, 15, 17};
   int m_cnt = 0, m_pre = 0, m_cks = 0;
   bit m_ovf = 0, m_mode = 0, m_en = 0, m_seen = 0, m_rst = 0;
   int per, n_cnt;
   bit tk, wcsr, wcnt, ev, n_ovf, n_seen;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_cks = 0;
         m_ovf = 0; m_mode = 0; m_en = 0; m_seen = 0; m_rst = 0;
      end else begin
         per  = 1 << shifts[m_cks];
         tk   = m_en && ((m_pre % per) == per - 1);
         wcsr = bus_wr && !bus_addr && (bus_wdata[15:8] == K);
         wcnt = bus_wr &&  bus_addr && (bus_wdata[15:8] == K);
         ev   = tk && !wcnt && (m_cnt == 255);
         if (!m_en)     n_cnt = 0;
         else if (wcnt) n_cnt = int'(bus_wdata[7:0]);
         else if (tk)   n_cnt = (m_cnt + 1) % 256;
         else           n_cnt = m_cnt;
         n_ovf = m_ovf;
         if (ev) n_ovf = 1;
         else if (wcsr && !bus_wdata[7] && m_seen) n_ovf = 0;
         n_seen = m_seen;
         if (wcsr) n_seen = 0;
         else if (bus_rd && !bus_addr && m_ovf) n_seen = 1;
         m_rst  = ev && m_mode && rst_en_i;
         m_pre  = m_en ? (m_pre + 1) % 131072 : 0;
         m_cnt  = n_cnt;
         m_ovf  = n_ovf;
         m_seen = n_seen;
         if (wcsr) begin
            m_mode = bus_wdata[6];
            m_en   = bus_wdata[5];
            m_cks  = int'(bus_wdata[2:0]);
         end
      end
   end

   function automatic int model_rdata(input logic a);
      if (a) return m_cnt;
      return (int'(m_ovf) << 7) | (int'(m_mode) << 6) | (int'(m_en) << 5) | 8'h18 | m_cks;
   endfunction

   always @(posedge clk) begin
      #2;
      total++;
      if (int'(bus_rdata) != model_rdata(bus_addr)) begin
         bad++;
         $display("FAIL R11 cycle compare rdata act=%0h exp=%0h", bus_rdata, model_rdata(bus_addr));
      end else if (irq_o != (m_ovf && !m_mode)) begin
         bad++;
         $display("FAIL R6 cycle compare irq act=%0b exp=%0b", irq_o, m_ovf && !m_mode);
      end else if (rst_req_o != m_rst) begin
         bad++;
         $display("FAIL R7 cycle compare rst_req act=%0b exp=%0b", rst_req_o, m_rst);
      end
   end

   always @(negedge clk) if (rst_n && rst_req_o) pulses++;

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] key, input logic [7:0] d);
      bus_addr = a; bus_wdata = {key, d}; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic look(input logic a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      int v;
      @(negedge clk);
      idle(3);
      rst_n = 1'b1;
      idle(1);
      look(0, v); chk("R1 reset csr", v, 8'h18);
      look(1, v); chk("R1 reset counter", v, 0);
      chk("R1 reset irq", int'(irq_o), 0);
      chk("R1 reset rst_req", int'(rst_req_o), 0);

      wr(0, 8'h33, 8'h21);
      look(0, v); chk("R8 bad key csr", v, 8'h18);
      wr(1, 8'hA5, 8'h40);
      look(1, v); chk("R8 bad key counter", v, 0);
      wr(1, K, 8'h40);
      look(1, v); chk("R9 load while disabled", v, 0);
      wr(0, K, 8'h00);
      look(0, v); chk("R10 fixed bits", v, 8'h18);

      wr(0, K, 8'h21);
      idle(640);
      look(1, v); chk("R3 div64 after 640", v, 10);
      look(0, v); chk("R11 csr view", v, 8'h39);

      wr(0, K, 8'h00); idle(1);
      look(1, v); chk("R2 disabled holds zero", v, 0);
      wr(0, K, 8'h22); idle(256);
      look(1, v); chk("R3 div128 after 256", v, 2);

      wr(0, K, 8'h00); idle(1);
      wr(0, K, 8'h23); idle(1024);
      look(1, v); chk("R3 div512 after 1024", v, 2);

      wr(0, K, 8'h00); idle(1);
      wr(0, K, 8'h27); idle(1000);
      look(1, v); chk("R3 div131072 still zero", v, 0);

      // overflow in interval mode
      wr(0, K, 8'h00); idle(1);
      wr(0, K, 8'h20);
      wr(1, K, 8'hFE);
      idle(2);
      look(1, v); chk("R9 loaded then ticked", v, 8'hFF);
      chk("R6 no irq before wrap", int'(irq_o), 0);
      idle(1);
      chk("R6 irq after wrap", int'(irq_o), 1);
      look(0, v); chk("R4 flag set", v, 8'hB8);
      idle(20);
      look(1, v); chk("R12 counts on after wrap", v, 10);

      // clearing protocol
      wr(0, K, 8'h20);
      chk("R5 write 0 without read", int'(irq_o), 1);
      rd(0);
      wr(0, K, 8'hA0);
      chk("R5 write 1 no effect", int'(irq_o), 1);
      wr(0, K, 8'h20);
      chk("R5 arm consumed by write", int'(irq_o), 1);
      rd(0);
      wr(0, K, 8'h20);
      chk("R5 read then write 0 clears", int'(irq_o), 0);

      // clear coinciding with overflow
      idle(520);
      chk("R4 natural overflow", int'(irq_o), 1);
      wr(0, K, 8'h01); idle(1);
      wr(0, K, 8'h21);
      wr(1, K, 8'hFF);
      rd(0);
      idle(61);
      wr(0, K, 8'h21);
      chk("R5 overflow beats clear", int'(irq_o), 1);
      look(1, v); chk("R4 wrapped to zero", v, 0);
      rd(0);
      wr(0, K, 8'h21);
      chk("R5 later clear works", int'(irq_o), 0);

      // watchdog mode
      wr(0, K, 8'h00); idle(1);
      rst_en_i = 1'b0;
      pulses = 0;
      wr(0, K, 8'h60);
      wr(1, K, 8'hFE);
      idle(6);
      chk("R7 no irq in watchdog", int'(irq_o), 0);
      look(0, v); chk("R4 flag in watchdog", v, 8'hF8);
      chk("R7 no request when gated", pulses, 0);
      rst_en_i = 1'b1;
      wr(1, K, 8'hFE);
      idle(10);
      chk("R7 one single-cycle request", pulses, 1);

      rst_n = 1'b0; idle(2);
      rst_n = 1'b1; idle(1);
      look(0, v); chk("R1 reset clears flag", v, 8'h18);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule